// File: doc/BRIEF.md
# Interrupt Source Gateway

This block sits between one device interrupt line and the pending-bit logic of an interrupt controller. It turns the raw signal into discrete requests and lets only one request be in flight at a time. Once a request has been raised, it holds that request until the pending logic takes it. It then stays closed until the handler signals completion for this source.

The block has two modes, chosen by a static select. In level mode the gateway forwards only the first assertion of the line. A line that is still high after completion is forwarded again straight away. In edge mode, each rising edge of the line counts as an event, and so does each cycle in which the message input is high. Events that arrive while a request is in flight are held in a saturating counter. Each one is released as its own request after a later completion, so a burst is not lost up to the counter limit.

Top module: `irq_gateway`

## Requirements
- R1: While reset is high, and in the cycle after it, `req_o` is low. Reset empties the edge counter, so a completion after reset raises no request.
- R2: In level mode (`edge_mode_i` = 0), `irq_i` high while idle raises `req_o` after the next clock edge. `req_o` stays high until a clock edge at which `req_ack_i` is high, and it falls after that edge.
- R3: Once a request has been accepted, no further request is raised until `cmpl_i` is seen, whatever the level of `irq_i`.
- R4: In level mode, a completion while `irq_i` is still high raises `req_o` after that same clock edge. A completion while `irq_i` is low returns the gateway to idle with `req_o` low.
- R5: In edge mode (`edge_mode_i` = 1), an event raises a request. An event is a 0-to-1 change of `irq_i` between consecutive clock edges, or `msg_i` high for one cycle. A line held high after its edge raises no second request after completion.
- R6: In edge mode, events that arrive while a request is outstanding are stored. Each later completion releases exactly one stored event as a new request, until the store is empty.
- R7: The store of events saturates at `MAX_PEND`. After a burst larger than that, exactly `MAX_PEND` further requests are released.
- R8: `req_ack_i` while no request is raised, and `cmpl_i` while the gateway is idle, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| edge_mode_i | input | 1 | Static mode select: 0 level, 1 edge |
| irq_i | input | 1 | Raw device interrupt line, synchronous to clk_i |
| msg_i | input | 1 | Message-style interrupt; each high cycle is one event |
| req_ack_i | input | 1 | Pulse from the pending logic: request taken |
| cmpl_i | input | 1 | Completion pulse for this source |
| req_o | output | 1 | Request toward the pending bit, held until acknowledged |

## Verification
Level mode is tried with a line held high across completion and with a line dropped before completion. These two cases separate immediate re-arming from a return to idle, and the first one also shows that a held line never re-fires while the request is outstanding. Edge mode is tried with a single edge on a held line, with a message pulse, and with two edges arriving while a request is in flight. Together they separate true edge detection from level following and show that each stored event is released once. A burst of five message events against a limit of three tells saturation apart from unbounded counting. A reset in the middle of a request shows that state is cleared.

// File: rtl/gw_pkg.sv
package gw_pkg;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_REQ  = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;

    typedef enum logic {
        GW_MODE_LEVEL = 1'b0,
        GW_MODE_EDGE  = 1'b1
    } gw_mode_e;

    typedef struct packed {
        logic event_hit;
        logic ready;
    } gw_src_t;

    function automatic logic gw_can_launch(gw_state_e st, logic done, logic ready);
        return ready && ((st == GW_IDLE) || ((st == GW_BUSY) && done));
    endfunction

endpackage

// File: rtl/gw_edge_detect.sv
module gw_edge_detect (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    input  logic msg_i,
    output logic event_o
);
    logic line_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) line_q <= 1'b0;
        else       line_q <= line_i;
    end

    assign event_o = (line_i & ~line_q) | msg_i;

endmodule

// File: rtl/gw_edge_counter.sv
module gw_edge_counter #(
    parameter int MAX_PEND = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic has_pend_o
);
    localparam int CW = (MAX_PEND < 2) ? 1 : $clog2(MAX_PEND + 1);
    localparam logic [CW:0] LIMIT = (CW + 1)'(MAX_PEND);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   sum;
    logic [CW-1:0] cnt_d;

    always_comb begin
        sum = {1'b0, cnt_q} + (CW + 1)'(inc_i);
        if (dec_i && (sum != '0)) sum = sum - 1'b1;
        if (sum > LIMIT) cnt_d = LIMIT[CW-1:0];
        else             cnt_d = sum[CW-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) cnt_q <= '0;
        else                cnt_q <= cnt_d;
    end

    assign has_pend_o = (cnt_q != '0);

    AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
        ({1'b0, cnt_q} <= LIMIT)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_i |-> (has_pend_o || inc_i)); // R6

endmodule

// File: rtl/gw_fsm.sv
module gw_fsm
    import gw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic ready_i,
    input  logic ack_i,
    input  logic done_i,
    output logic launch_o,
    output logic req_o
);
    gw_state_e st_q, st_d;

    assign launch_o = gw_can_launch(st_q, done_i, ready_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GW_IDLE: if (ready_i) st_d = GW_REQ;
            GW_REQ:  if (ack_i)   st_d = GW_BUSY;
            GW_BUSY: if (done_i)  st_d = ready_i ? GW_REQ : GW_IDLE;
            default:              st_d = GW_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= GW_IDLE;
        else       st_q <= st_d;
    end

    assign req_o = (st_q == GW_REQ);

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_o && !ack_i) |=> req_o); // R2
    AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_q == GW_BUSY) && !done_i) |=> !req_o); // R3
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_q == GW_IDLE) && done_i && !ready_i) |=> !req_o); // R8

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
    import gw_pkg::*;
#(
    parameter int MAX_PEND = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic edge_mode_i,
    input  logic irq_i,
    input  logic msg_i,
    input  logic req_ack_i,
    input  logic cmpl_i,
    output logic req_o
);
    gw_mode_e mode;
    gw_src_t  src;
    logic     event_raw;
    logic     has_pend;
    logic     launch;

    assign mode = edge_mode_i ? GW_MODE_EDGE : GW_MODE_LEVEL;

    gw_edge_detect u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .line_i (irq_i),
        .msg_i  (msg_i),
        .event_o(event_raw)
    );

    assign src.event_hit = (mode == GW_MODE_EDGE) && event_raw;

    generate
        if (MAX_PEND > 0) begin : g_store
            gw_edge_counter #(.MAX_PEND(MAX_PEND)) u_cnt (
                .clk_i     (clk_i),
                .rst_i     (rst_i),
                .clr_i     (mode == GW_MODE_LEVEL),
                .inc_i     (src.event_hit),
                .dec_i     (launch && (mode == GW_MODE_EDGE)),
                .has_pend_o(has_pend)
            );
        end else begin : g_nostore
            assign has_pend = 1'b0;
        end
    endgenerate

    assign src.ready = (mode == GW_MODE_EDGE) ? (src.event_hit || has_pend) : irq_i;

    gw_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ready_i (src.ready),
        .ack_i   (req_ack_i),
        .done_i  (cmpl_i),
        .launch_o(launch),
        .req_o   (req_o)
    );

    AST_LVL_REARM: assert property (@(posedge clk_i) disable iff (rst_i)
        (!edge_mode_i && !req_o && cmpl_i && irq_i) |=> req_o); // R4
    AST_EDGE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (edge_mode_i && !req_o && !event_raw && !has_pend) |=> !req_o); // R5

endmodule

// File: tb/irq_gateway_tb.sv
`timescale 1ns/1ps
module irq_gateway_tb;

    logic clk = 1'b0;
    logic rst, edge_mode, irq, msg, ack, cmpl;
    logic req;
    int   n_checks = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    irq_gateway #(.MAX_PEND(3)) u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .edge_mode_i(edge_mode),
        .irq_i      (irq),
        .msg_i      (msg),
        .req_ack_i  (ack),
        .cmpl_i     (cmpl),
        .req_o      (req)
    );

    // {edge_mode, irq, msg, ack, cmpl, expected req after the edge, req tag}
    localparam int NV = 31;
    localparam logic [9:0] VEC [NV] = '{
        {5'b00000, 1'b0, 4'd1}, // idle after reset
        {5'b01000, 1'b1, 4'd2}, // level high -> request
        {5'b01000, 1'b1, 4'd2}, // held until ack
        {5'b01010, 1'b0, 4'd2}, // ack drops request
        {5'b01000, 1'b0, 4'd3}, // no refire while busy
        {5'b01000, 1'b0, 4'd3},
        {5'b01001, 1'b1, 4'd4}, // completion with line high rearms
        {5'b01010, 1'b0, 4'd2},
        {5'b00000, 1'b0, 4'd3},
        {5'b00001, 1'b0, 4'd4}, // completion with line low -> idle
        {5'b00000, 1'b0, 4'd4},
        {5'b00001, 1'b0, 4'd8}, // completion while idle ignored
        {5'b00010, 1'b0, 4'd8}, // ack without request ignored
        {5'b01000, 1'b1, 4'd2},
        {5'b00010, 1'b0, 4'd2},
        {5'b00001, 1'b0, 4'd4},
        {5'b10000, 1'b0, 4'd5}, // edge mode, line low
        {5'b11000, 1'b1, 4'd5}, // rising edge
        {5'b11010, 1'b0, 4'd5},
        {5'b11001, 1'b0, 4'd5}, // held line, no second request
        {5'b10000, 1'b0, 4'd5},
        {5'b10100, 1'b1, 4'd5}, // message pulse acts as edge
        {5'b10010, 1'b0, 4'd5},
        {5'b11000, 1'b0, 4'd6}, // edge while busy stored
        {5'b10000, 1'b0, 4'd6},
        {5'b11000, 1'b0, 4'd6}, // second stored edge
        {5'b10001, 1'b1, 4'd6}, // completion releases one
        {5'b10010, 1'b0, 4'd6},
        {5'b10001, 1'b1, 4'd6}, // completion releases the other
        {5'b10010, 1'b0, 4'd6},
        {5'b10001, 1'b0, 4'd6}  // store empty
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic exp, input int tag, input string what);
        n_checks++;
        if (req !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: req_o=%b expected %b", tag, what, req, exp);
        end
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL R0 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int got;
        rst = 1'b1; edge_mode = 1'b0; irq = 1'b0; msg = 1'b0; ack = 1'b0; cmpl = 1'b0;
        tick(); tick();
        check(1'b0, 1, "during reset"); // R1
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {edge_mode, irq, msg, ack, cmpl} = VEC[i][9:5];
            tick();
            check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end
        {irq, msg, ack, cmpl} = 4'b0000;

        // R7: one in flight, then a burst of five message events
        edge_mode = 1'b1;
        msg = 1'b1; tick(); msg = 1'b0;
        check(1'b1, 7, "burst first request");
        ack = 1'b1; tick(); ack = 1'b0;
        msg = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        msg = 1'b0;
        check(1'b0, 7, "busy during burst");
        got = 0;
        for (int k = 0; k < 6; k++) begin
            cmpl = 1'b1; tick(); cmpl = 1'b0;
            if (req === 1'b1) begin
                got++;
                ack = 1'b1; tick(); ack = 1'b0;
            end
        end
        n_checks++;
        if (got != 3) begin
            n_fail++;
            $display("FAIL R7 saturated releases: got %0d expected %0d", got, 3);
        end

        // R1: reset in the middle of a request clears everything
        msg = 1'b1; tick(); msg = 1'b0;
        ack = 1'b1; tick(); ack = 1'b0;
        msg = 1'b1; tick(); tick(); msg = 1'b0;
        rst = 1'b1; tick();
        check(1'b0, 1, "reset mid operation");
        rst = 1'b0; tick();
        check(1'b0, 1, "cycle after reset");
        cmpl = 1'b1; tick(); cmpl = 1'b0;
        check(1'b0, 1, "store empty after reset");

        // R8: ack while idle in edge mode has no effect
        ack = 1'b1; tick(); ack = 1'b0;
        check(1'b0, 8, "edge idle ack ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule